// File: doc/BRIEF.md
# Network Controller Control, Status and Interrupt Registers

This block holds the control, status and interrupt registers of a small Ethernet media access controller. Software reaches it through a plain register bus: an 8-bit address, a write strobe with 8-bit write data, and a read strobe with combinational 8-bit read data. The transmit and receive machinery reports events as single-cycle pulses. These events are transmit done, frame received, receive overflow and overflow-counter overflow. The block turns them into status flags and a level interrupt.

The block tracks which of two transmit slots is active. Each slot has its own completion flag, and the active slot flips after every completed send. Writing the soft-reset bit of the control register clears the register set. A few bits survive it: the wake-enable and external-PHY bits of control, and the wake-status bit of status. Full duplex is always reported as on and the link is always reported as up.

Top module: `mac_ctrl_irq`

## Requirements
- R1: After a hardware reset the registers read control 0x08, status 0x40, transmit control 0x00, interrupt status 0x00 and interrupt mask 0x00. The slot index is 0, the interrupt line is low and linkUp is high. linkUp always shows status bit 6.
- R2: A read with busRdEn high returns control at 0x00, status at 0x01, transmit control at 0x02, interrupt status at 0xFE (bits 7:4 read 0) and interrupt mask at 0xFF. Any other address returns 0, and busRdData is 0 while busRdEn is low. Reads change no state.
- R3: A write to 0x00 with bit 0 clear stores the written value with bit 3 (full duplex) forced to 1.
- R4: A write to 0x00 with bit 0 set is a soft reset. Control becomes (written value AND 0xC0) OR 0x08, and status becomes (old status AND 0x20) OR 0x40. Transmit control, interrupt status, interrupt mask and the slot index become 0. A soft reset overrides any event in the same cycle.
- R5: A write to 0x01 clears each of status bits 5, 3 and 2 whose written bit is 1, and leaves bits with a written 0 unchanged. Bits 7, 6, 4, 1 and 0 are never changed by a write.
- R6: A transmit-done pulse sets status bit (2 + slot index) and interrupt status bit 1, then toggles the slot index shown on txSlotIdx.
- R7: A frame-received pulse sets interrupt status bit 0. A receive-overflow pulse sets bit 2, and an overflow-counter pulse sets bit 3.
- R8: Writing 1 to an interrupt status bit at 0xFE clears it. When an event that sets a status or interrupt status bit arrives in the same cycle as the write-1-to-clear of that bit, the bit ends up set.
- R9: irqOut is high exactly when (interrupt status AND interrupt mask) is nonzero in bits 3:0. All 8 mask bits are stored and read back, and bits 7:4 (bit 7 being the receive auto-wrap enable) have no effect on irqOut.
- R10: A write to 0x02 stores all 8 bits, which read back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous hardware reset, active low |
| busAddr | input | ADDR_W (8) | Register address |
| busWrEn | input | 1 | Write strobe, one cycle per write |
| busWrData | input | 8 | Write data |
| busRdEn | input | 1 | Read strobe |
| busRdData | output | 8 | Read data, combinational, 0 when not reading |
| txDoneEvt | input | 1 | Transmit-complete pulse |
| rxFrameEvt | input | 1 | Frame-received pulse |
| rxOverflowEvt | input | 1 | Receive-overflow pulse |
| cntOverflowEvt | input | 1 | Overflow-counter overflow pulse |
| irqOut | output | 1 | Level interrupt |
| txSlotIdx | output | 1 | Currently active transmit slot |
| linkUp | output | 1 | Link status (status bit 6) |

## Verification
The bench builds the block with its default parameters: an 8-bit address and the register addresses 0x00, 0x01, 0x02, 0xFE and 0xFF. With that setup the whole address space is small enough to read every address. Every control and transmit-control value, every status clear pattern, and every pairing of interrupt event pattern with mask nibble are each swept in full against an arithmetic model. Same-cycle collisions are driven directly: event against clear, and event against soft reset.

// File: rtl/mac_ctrl_pkg.sv
`timescale 1ns/1ps
package mac_ctrl_pkg;
  localparam int REG_W = 8;
  localparam int EVT_W = 4;          // rx, tx, rx overflow, counter overflow
  localparam int EVT_RX = 0;
  localparam int EVT_TX = 1;
  localparam int TX_FLAG_LSB = 2;    // status bit for slot 0; slot 1 is next
  localparam logic [REG_W-1:0] FDX_MASK  = 8'h08;
  localparam logic [REG_W-1:0] LINK_MASK = 8'h40;
  localparam logic [REG_W-1:0] NCR_KEEP  = 8'hC0;
  localparam logic [REG_W-1:0] NSR_KEEP  = 8'h20;
  localparam logic [REG_W-1:0] NSR_W1C   = 8'h2C;

  typedef struct packed {
    logic wrNcr;
    logic wrNsr;
    logic wrTcr;
    logic wrIsr;
    logic wrImr;
    logic softRst;
  } regStrobe_t;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_NCR, SEL_NSR, SEL_TCR, SEL_ISR, SEL_IMR
  } rdSel_t;
endpackage

// File: rtl/mac_ctrl_decode.sv
`timescale 1ns/1ps
module mac_ctrl_decode
  import mac_ctrl_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] NCR_ADDR = 'h00,
  parameter logic [ADDR_W-1:0] NSR_ADDR = 'h01,
  parameter logic [ADDR_W-1:0] TCR_ADDR = 'h02,
  parameter logic [ADDR_W-1:0] ISR_ADDR = 'hFE,
  parameter logic [ADDR_W-1:0] IMR_ADDR = 'hFF
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic              rstBit,
  output regStrobe_t        strb,
  output rdSel_t            rdSel
);
  logic hitNcr, hitNsr, hitTcr, hitIsr, hitImr;

  always_comb begin
    hitNcr = (busAddr == NCR_ADDR);
    hitNsr = (busAddr == NSR_ADDR);
    hitTcr = (busAddr == TCR_ADDR);
    hitIsr = (busAddr == ISR_ADDR);
    hitImr = (busAddr == IMR_ADDR);
  end

  always_comb begin
    strb.softRst = busWrEn && hitNcr && rstBit;
    strb.wrNcr   = busWrEn && hitNcr && !rstBit;
    strb.wrNsr   = busWrEn && hitNsr;
    strb.wrTcr   = busWrEn && hitTcr;
    strb.wrIsr   = busWrEn && hitIsr;
    strb.wrImr   = busWrEn && hitImr;
  end

  always_comb begin
    rdSel = SEL_NONE;
    if (busRdEn) begin
      if (hitNcr)      rdSel = SEL_NCR;
      else if (hitNsr) rdSel = SEL_NSR;
      else if (hitTcr) rdSel = SEL_TCR;
      else if (hitIsr) rdSel = SEL_ISR;
      else if (hitImr) rdSel = SEL_IMR;
    end
  end
endmodule

// File: rtl/mac_ctrl_datapath.sv
`timescale 1ns/1ps
module mac_ctrl_datapath
  import mac_ctrl_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  regStrobe_t       strb,
  input  rdSel_t           rdSel,
  input  logic [REG_W-1:0] wrData,
  input  logic [EVT_W-1:0] evt,
  output logic [REG_W-1:0] rdData,
  output logic             irq,
  output logic             txSlot,
  output logic             linkUp,
  output logic [EVT_W-1:0] isrVal,
  output logic [REG_W-1:0] nsrVal
);
  logic [REG_W-1:0] ncrQ, nsrQ, nsrNext, tcrQ, imrQ;
  logic [EVT_W-1:0] isrQ;
  logic             slotQ;

  // Network control: duplex forced on every store
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             ncrQ <= FDX_MASK;
    else if (strb.softRst) ncrQ <= (wrData & NCR_KEEP) | FDX_MASK;
    else if (strb.wrNcr)   ncrQ <= wrData | FDX_MASK;
  end

  // Network status: clear-by-write on a subset, event set wins, reset keeps wake bit
  always_comb begin
    nsrNext = nsrQ;
    if (strb.wrNsr) nsrNext = nsrQ & ~(wrData & NSR_W1C);
    if (evt[EVT_TX]) nsrNext[TX_FLAG_LSB + int'(slotQ)] = 1'b1;
    if (strb.softRst) nsrNext = (nsrQ & NSR_KEEP) | LINK_MASK;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) nsrQ <= LINK_MASK;
    else       nsrQ <= nsrNext;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             tcrQ <= '0;
    else if (strb.softRst) tcrQ <= '0;
    else if (strb.wrTcr)   tcrQ <= wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             imrQ <= '0;
    else if (strb.softRst) imrQ <= '0;
    else if (strb.wrImr)   imrQ <= wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             slotQ <= 1'b0;
    else if (strb.softRst) slotQ <= 1'b0;
    else if (evt[EVT_TX])  slotQ <= ~slotQ;
  end

  // Interrupt status: one latch per event source
  for (genvar i = 0; i < EVT_W; i++) begin : g_isr
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                          isrQ[i] <= 1'b0;
      else if (strb.softRst)              isrQ[i] <= 1'b0;
      else if (evt[i])                    isrQ[i] <= 1'b1;
      else if (strb.wrIsr && wrData[i])   isrQ[i] <= 1'b0;
    end
  end

  always_comb begin
    case (rdSel)
      SEL_NCR: rdData = ncrQ;
      SEL_NSR: rdData = nsrQ;
      SEL_TCR: rdData = tcrQ;
      SEL_ISR: rdData = {{(REG_W-EVT_W){1'b0}}, isrQ};
      SEL_IMR: rdData = imrQ;
      default: rdData = '0;
    endcase
  end

  assign irq    = |(isrQ & imrQ[EVT_W-1:0]);
  assign txSlot = slotQ;
  assign linkUp = nsrQ[6];
  assign isrVal = isrQ;
  assign nsrVal = nsrQ;
endmodule

// File: rtl/mac_ctrl_irq.sv
`timescale 1ns/1ps
module mac_ctrl_irq
  import mac_ctrl_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] NCR_ADDR = 'h00,
  parameter logic [ADDR_W-1:0] NSR_ADDR = 'h01,
  parameter logic [ADDR_W-1:0] TCR_ADDR = 'h02,
  parameter logic [ADDR_W-1:0] ISR_ADDR = 'hFE,
  parameter logic [ADDR_W-1:0] IMR_ADDR = 'hFF
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [7:0]        busWrData,
  input  logic              busRdEn,
  output logic [7:0]        busRdData,
  input  logic              txDoneEvt,
  input  logic              rxFrameEvt,
  input  logic              rxOverflowEvt,
  input  logic              cntOverflowEvt,
  output logic              irqOut,
  output logic              txSlotIdx,
  output logic              linkUp
);
  regStrobe_t       strb;
  rdSel_t           rdSel;
  logic [EVT_W-1:0] evtVec;
  logic [EVT_W-1:0] isrVal;
  logic [REG_W-1:0] nsrVal;

  assign evtVec = {cntOverflowEvt, rxOverflowEvt, txDoneEvt, rxFrameEvt};

  mac_ctrl_decode #(
    .ADDR_W(ADDR_W), .NCR_ADDR(NCR_ADDR), .NSR_ADDR(NSR_ADDR),
    .TCR_ADDR(TCR_ADDR), .ISR_ADDR(ISR_ADDR), .IMR_ADDR(IMR_ADDR)
  ) u_decode (
    .busAddr (busAddr),
    .busWrEn (busWrEn),
    .busRdEn (busRdEn),
    .rstBit  (busWrData[0]),
    .strb    (strb),
    .rdSel   (rdSel)
  );

  mac_ctrl_datapath u_data (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .rdSel  (rdSel),
    .wrData (busWrData),
    .evt    (evtVec),
    .rdData (busRdData),
    .irq    (irqOut),
    .txSlot (txSlotIdx),
    .linkUp (linkUp),
    .isrVal (isrVal),
    .nsrVal (nsrVal)
  );
endmodule

// File: rtl/mac_ctrl_irq_chk.sv
`timescale 1ns/1ps
module mac_ctrl_irq_chk #(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] NCR_ADDR = 'h00,
  parameter logic [ADDR_W-1:0] NSR_ADDR = 'h01,
  parameter logic [ADDR_W-1:0] IMR_ADDR = 'hFF
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWrEn,
  input logic [7:0]        busWrData,
  input logic              busRdEn,
  input logic [7:0]        busRdData,
  input logic              txDoneEvt,
  input logic              rxFrameEvt,
  input logic              irqOut,
  input logic              txSlotIdx,
  input logic              linkUp,
  input logic [3:0]        isrVal,
  input logic [7:0]        nsrVal
);
  logic softRst;
  assign softRst = busWrEn && (busAddr == NCR_ADDR) && busWrData[0];

  a_r3_fdx_reads_one: assert property (@(posedge clk) disable iff (!rstN)
    (busRdEn && busAddr == NCR_ADDR) |-> busRdData[3]);

  a_r1_link_reported: assert property (@(posedge clk) disable iff (!rstN)
    (busRdEn && busAddr == NSR_ADDR) |-> (busRdData[6] && linkUp));

  a_r6_slot_toggles: assert property (@(posedge clk) disable iff (!rstN)
    (txDoneEvt && !softRst) |=> (txSlotIdx != $past(txSlotIdx)));

  a_r6_slot_flag_set: assert property (@(posedge clk) disable iff (!rstN)
    (txDoneEvt && !softRst) |=>
      (isrVal[1] && ($past(txSlotIdx) ? nsrVal[3] : nsrVal[2])));

  a_r8_rx_event_wins: assert property (@(posedge clk) disable iff (!rstN)
    (rxFrameEvt && !softRst) |=> isrVal[0]);

  a_r4_soft_reset: assert property (@(posedge clk) disable iff (!rstN)
    softRst |=> (nsrVal == (($past(nsrVal) & 8'h20) | 8'h40)
                 && isrVal == 4'h0 && !txSlotIdx && !irqOut));

  a_r5_readonly_bits: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == NSR_ADDR) |=>
      ((nsrVal & 8'hD3) == ($past(nsrVal) & 8'hD3)));

  a_r9_mask_blocks: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == IMR_ADDR && busWrData[3:0] == 4'h0) |=> !irqOut);
endmodule

bind mac_ctrl_irq mac_ctrl_irq_chk #(
  .ADDR_W(ADDR_W), .NCR_ADDR(NCR_ADDR), .NSR_ADDR(NSR_ADDR), .IMR_ADDR(IMR_ADDR)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .busAddr    (busAddr),
  .busWrEn    (busWrEn),
  .busWrData  (busWrData),
  .busRdEn    (busRdEn),
  .busRdData  (busRdData),
  .txDoneEvt  (txDoneEvt),
  .rxFrameEvt (rxFrameEvt),
  .irqOut     (irqOut),
  .txSlotIdx  (txSlotIdx),
  .linkUp     (linkUp),
  .isrVal     (isrVal),
  .nsrVal     (nsrVal)
);

// File: tb/sim_mac_ctrl_irq.sv
`timescale 1ns/1ps
module sim_mac_ctrl_irq;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] busAddr = '0;
  logic       busWrEn = 1'b0;
  logic [7:0] busWrData = '0;
  logic       busRdEn = 1'b0;
  logic [7:0] busRdData;
  logic       txDoneEvt = 1'b0, rxFrameEvt = 1'b0;
  logic       rxOverflowEvt = 1'b0, cntOverflowEvt = 1'b0;
  logic       irqOut, txSlotIdx, linkUp;

  int  nCmp = 0;
  int  nBad = 0;
  bit  done = 0;

  // bench model
  logic [7:0] mNcr, mNsr, mTcr, mImr;
  logic [3:0] mIsr;
  logic       mSlot;

  always #2.5 clk = ~clk;

  mac_ctrl_irq u0 (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdEn(busRdEn), .busRdData(busRdData),
    .txDoneEvt(txDoneEvt), .rxFrameEvt(rxFrameEvt),
    .rxOverflowEvt(rxOverflowEvt), .cntOverflowEvt(cntOverflowEvt),
    .irqOut(irqOut), .txSlotIdx(txSlotIdx), .linkUp(linkUp)
  );

  task automatic modelReset();
    mNcr = 8'h08; mNsr = 8'h40; mTcr = 8'h00; mImr = 8'h00; mIsr = 4'h0; mSlot = 1'b0;
  endtask

  // ev: [0] frame received, [1] transmit done, [2] rx overflow, [3] counter overflow
  task automatic modelStep(input logic wr, input logic [7:0] a, input logic [7:0] d,
                           input logic [3:0] ev);
    logic [7:0] nNsr;
    logic [3:0] nIsr;
    if (wr && a == 8'h00 && d[0]) begin
      mNcr = (d & 8'hC0) | 8'h08;
      mNsr = (mNsr & 8'h20) | 8'h40;
      mTcr = 0; mIsr = 0; mImr = 0; mSlot = 0;
      return;
    end
    nNsr = mNsr;
    nIsr = mIsr;
    if (wr) begin
      case (a)
        8'h00: mNcr = d | 8'h08;
        8'h01: nNsr = mNsr & ~(d & 8'h2C);
        8'h02: mTcr = d;
        8'hFE: nIsr = mIsr & ~d[3:0];
        8'hFF: mImr = d;
        default: ;
      endcase
    end
    if (ev[1]) begin
      if (mSlot) nNsr[3] = 1'b1; else nNsr[2] = 1'b1;
      mSlot = ~mSlot;
    end
    nIsr = nIsr | ev;
    mNsr = nNsr;
    mIsr = nIsr;
  endtask

  function automatic logic [7:0] expRead(input logic [7:0] a);
    case (a)
      8'h00: return mNcr;
      8'h01: return mNsr;
      8'h02: return mTcr;
      8'hFE: return {4'h0, mIsr};
      8'hFF: return mImr;
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    nCmp++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // called right after a falling edge; returns at the next falling edge
  task automatic step(input logic wr, input logic [7:0] a, input logic [7:0] d,
                      input logic [3:0] ev);
    busWrEn = wr; busAddr = a; busWrData = d;
    rxFrameEvt = ev[0]; txDoneEvt = ev[1]; rxOverflowEvt = ev[2]; cntOverflowEvt = ev[3];
    @(posedge clk);
    #1;
    busWrEn = 0; rxFrameEvt = 0; txDoneEvt = 0; rxOverflowEvt = 0; cntOverflowEvt = 0;
    modelStep(wr, a, d, ev);
    @(negedge clk);
  endtask

  task automatic rdChk(input logic [7:0] a, input string tag);
    busAddr = a; busRdEn = 1'b1;
    #0.5;
    chk(tag, busRdData, expRead(a));
    busRdEn = 1'b0;
    #0.5;
  endtask

  task automatic outChk(input string tag);
    chk({tag, " irqOut"}, {7'b0, irqOut}, {7'b0, |(mIsr & mImr[3:0])});
    chk({tag, " txSlotIdx"}, {7'b0, txSlotIdx}, {7'b0, mSlot});
    chk({tag, " linkUp"}, {7'b0, linkUp}, {7'b0, mNsr[6]});
  endtask

  task automatic allRegs(input string tag);
    rdChk(8'h00, tag); rdChk(8'h01, tag); rdChk(8'h02, tag);
    rdChk(8'hFE, tag); rdChk(8'hFF, tag);
    outChk(tag);
  endtask

  initial begin
    modelReset();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: hardware reset values
    allRegs("R1 reset");
    chk("R1 linkUp high", {7'b0, linkUp}, 8'h01);

    // R2: full address sweep, then read strobe low
    for (int a = 0; a < 256; a++) rdChk(8'(a), "R2 address sweep");
    busAddr = 8'h00; busRdEn = 1'b0; #0.5;
    chk("R2 no read strobe", busRdData, 8'h00);
    #0.5;

    // R3 / R4: every control value, soft resets on loaded state
    for (int v = 0; v < 256; v++) begin
      if (v[0]) begin
        step(1, 8'hFF, 8'(v ^ 8'h5A), 4'h0);
        step(1, 8'h02, 8'hA5, 4'h0);
        step(0, 8'h00, 8'h00, 4'hF);
        step(1, 8'h00, 8'(v), 4'h0);
        allRegs("R4 soft reset");
      end else begin
        step(1, 8'h00, 8'(v), 4'h0);
        rdChk(8'h00, "R3 control store");
      end
    end

    // R5 / R6: status clear patterns with both slot flags set
    for (int w = 0; w < 256; w++) begin
      step(0, 8'h00, 8'h00, 4'b0010);
      outChk("R6 slot after first send");
      step(0, 8'h00, 8'h00, 4'b0010);
      rdChk(8'h01, "R6 both slot flags");
      step(1, 8'h01, 8'(w), 4'h0);
      rdChk(8'h01, "R5 status clear");
      outChk("R5 outputs");
    end

    // R7 / R9: every event pattern against every mask nibble
    for (int s = 0; s < 16; s++) begin
      for (int m = 0; m < 16; m++) begin
        step(1, 8'hFE, 8'h0F, 4'h0);
        step(1, 8'hFF, {4'(s + m), 4'(m)}, 4'h0);
        step(0, 8'h00, 8'h00, 4'(s));
        rdChk(8'hFE, "R7 event latch");
        rdChk(8'hFF, "R9 mask readback");
        outChk("R9 irq");
      end
    end

    // R8: event against clear in the same cycle
    step(1, 8'hFF, 8'h0F, 4'h0);
    step(0, 8'h00, 8'h00, 4'hF);
    step(1, 8'hFE, 8'h0F, 4'b0001);
    rdChk(8'hFE, "R8 event wins over clear");
    outChk("R8 irq");
    step(1, 8'hFE, 8'h0F, 4'b0000);
    rdChk(8'hFE, "R8 clear all");
    outChk("R8 irq low");
    step(1, 8'h01, 8'h2C, 4'b0010);
    rdChk(8'h01, "R8 tx flag wins over clear");
    step(1, 8'h01, 8'h2C, 4'b0010);
    rdChk(8'h01, "R8 other slot flag wins");

    // R4: soft reset beats same-cycle events
    step(1, 8'h00, 8'hC1, 4'hF);
    allRegs("R4 reset beats events");

    // R10: transmit control sweep
    for (int t = 0; t < 256; t++) begin
      step(1, 8'h02, 8'(t), 4'h0);
      rdChk(8'h02, "R10 transmit control");
    end

    // R2: repeated reads have no side effects
    step(0, 8'h00, 8'h00, 4'b0101);
    rdChk(8'hFE, "R2 read once");
    rdChk(8'hFE, "R2 read twice");
    allRegs("R2 after reads");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nCmp++;
      nBad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end
endmodule